// File: doc/BRIEF.md
# Display Power State Detector

This block classifies a monitor's power state from its two sync inputs. It watches the horizontal and the vertical sync lines, decides for each whether pulses are arriving, and maps the pair of activity flags onto one of four states: on, standby, suspend and off. Each line may use either polarity. Activity is judged on transitions, so a line parked at either level counts as silent.

A state change that leaves the on state must be qualified. The non-on condition has to hold for a long run of consecutive reference-clock cycles. By default this is 163840 cycles, which is 5 s at 32768 Hz. The delay stops mode changes and resolution switches from blanking the display. Moves between saving states, and any return to on, take effect on the next clock. A test input forces the on state, for burn-in and diagnostics.

The block is clocked from a low-frequency reference. It drives one active-low indicator for each saving state, plus a combined indicator for the two light saving states.

Top module: `dpd_power_detect`

## Requirements
- R1: With both lines active the block goes to, or stays in, the on state, and all four indicators read high.
- R2: With horizontal silent and vertical active the state is standby: `stby_n` low, `save_n` low, the others high.
- R3: With horizontal active and vertical silent the state is suspend: `susp_n` low, `save_n` low, the others high.
- R4: With both lines silent the state is off: `off_n` low and the other three high.
- R5: The block leaves the on state only after QUAL_CYCLES consecutive cycles in which the decoded target is not on. A shorter non-on spell leaves it in on, and the count starts again from zero.
- R6: From any saving state the block moves to the newly decoded state on the clock after the activity flags change, with no qualification delay.
- R7: Each line is judged on transitions only. Idle-low with high pulses and idle-high with low pulses both count as active. A line held constant at either level counts as silent.
- R8: A line becomes silent once no transition has reached the block for H_TIMEOUT (horizontal) or V_TIMEOUT (vertical) cycles. Inputs pass a SYNC_STAGES-deep synchroniser first.
- R9: While `force_on` is high the decoded target is on. From a saving state the block returns to on on the next clock, and while forced it never leaves on.
- R10: At most one of `stby_n`, `susp_n` and `off_n` is low at any time. `save_n` is low exactly when standby or suspend is indicated.
- R11: A synchronous active-low reset puts the block in the on state with both lines counted as silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, either polarity, asynchronous |
| vsync_in | input | 1 | Vertical sync, either polarity, asynchronous |
| force_on | input | 1 | Forces the on state; synchronous to clk |
| stby_n | output | 1 | Low in standby |
| susp_n | output | 1 | Low in suspend |
| off_n | output | 1 | Low in off |
| save_n | output | 1 | Low in standby or suspend |

## Verification
The bench drops the horizontal line in the on state and samples in the middle of qualification. A design that left on early, or that never left, fails there. It also drops the vertical line for a spell shorter than the qualification window; a design that does not restart its count would wrongly fall into a saving state. Lines are parked high as well as low, and one pulse train uses negative polarity. A level-sensitive detector would misread the parked-high line as active, or miss the inverted pulses. The override is raised from the off state and held for longer than the qualification window, then released. A design that kept a stale count across the override would leave on too soon.

// File: rtl/dpd_pkg.sv
// Shared types for the display power state detector.
// Assumes the state encoding is only used inside the block and its checker.
package dpd_pkg;

    typedef enum logic [1:0] {
        PWR_ON      = 2'd0,
        PWR_STANDBY = 2'd1,
        PWR_SUSPEND = 2'd2,
        PWR_OFF     = 2'd3
    } pwr_state_t;

    // Maps the two activity flags and the override onto the wanted state.
    function automatic pwr_state_t decode_power(input logic h_act,
                                                input logic v_act,
                                                input logic force_on);
        pwr_state_t s;
        if (force_on || (h_act && v_act)) s = PWR_ON;
        else if (v_act)                   s = PWR_STANDBY;
        else if (h_act)                   s = PWR_SUSPEND;
        else                              s = PWR_OFF;
        return s;
    endfunction

endpackage

// File: rtl/dpd_sync_edge.sv
// Synchronises one asynchronous sync line into clk and flags any transition.
// Assumes STAGES >= 2. One extra flop holds the previous synchronised value,
// so the edge flag is polarity independent.
module dpd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_seen
);
    localparam int TAPS = STAGES + 1;

    logic [TAPS-1:0] chain_q;

    // Shift the raw input through the synchroniser and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[TAPS-2:0], din};
    end

    // A transition is a difference between the newest safe sample and its predecessor.
    assign edge_seen = chain_q[STAGES-1] ^ chain_q[STAGES];

endmodule

// File: rtl/dpd_activity_timer.sv
// Counts cycles since the last transition on one line and saturates at TIMEOUT.
// The line is active while the count is below TIMEOUT. After reset the line is silent.
module dpd_activity_timer #(
    parameter int TIMEOUT = 328
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_seen,
    output logic active
);
    localparam int              CW    = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0]   LIMIT = CW'(TIMEOUT);

    logic [CW-1:0] idle_q;

    // Restart on a transition, otherwise count up to the limit and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)              idle_q <= LIMIT;
        else if (edge_seen)      idle_q <= '0;
        else if (idle_q < LIMIT) idle_q <= idle_q + 1'b1;
    end

    assign active = (idle_q < LIMIT);

endmodule

// File: rtl/dpd_state_ctrl.sv
// Holds the power state. Leaving on needs QUAL_CYCLES consecutive non-on
// targets; every other move is taken on the next clock.
// Assumes force_on is synchronous to clk.
module dpd_state_ctrl
    import dpd_pkg::*;
#(
    parameter int QUAL_CYCLES = 163840
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       h_active,
    input  logic       v_active,
    input  logic       force_on,
    output pwr_state_t state_q
);
    localparam int            QW    = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
    localparam logic [QW-1:0] QLAST = QW'(QUAL_CYCLES - 1);

    logic [QW-1:0] qual_q;
    pwr_state_t    target;

    // Wanted state from the current activity flags.
    always_comb target = decode_power(h_active, v_active, force_on);

    // State register and qualification counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PWR_ON;
            qual_q  <= '0;
        end else if (state_q == PWR_ON) begin
            if (target == PWR_ON) begin
                qual_q <= '0;
            end else if (qual_q == QLAST) begin
                state_q <= target;
                qual_q  <= '0;
            end else begin
                qual_q <= qual_q + 1'b1;
            end
        end else begin
            state_q <= target;
            qual_q  <= '0;
        end
    end

endmodule

// File: rtl/dpd_power_detect.sv
// Top of the display power state detector: two synchronised edge detectors,
// two activity timers, the state controller and the active-low indicator decode.
// Assumes clk is the low-frequency reference and the timeouts are set in its cycles.
module dpd_power_detect
    import dpd_pkg::*;
#(
    parameter int QUAL_CYCLES = 163840,
    parameter int H_TIMEOUT   = 328,
    parameter int V_TIMEOUT   = 3277,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic force_on,
    output logic stby_n,
    output logic susp_n,
    output logic off_n,
    output logic save_n
);
    logic       h_edge, v_edge;
    logic       h_active, v_active;
    pwr_state_t cur_state;

    dpd_sync_edge #(.STAGES(SYNC_STAGES)) u_h_sync (
        .clk(clk), .rst_n(rst_n), .din(hsync_in), .edge_seen(h_edge)
    );

    dpd_sync_edge #(.STAGES(SYNC_STAGES)) u_v_sync (
        .clk(clk), .rst_n(rst_n), .din(vsync_in), .edge_seen(v_edge)
    );

    dpd_activity_timer #(.TIMEOUT(H_TIMEOUT)) u_h_timer (
        .clk(clk), .rst_n(rst_n), .edge_seen(h_edge), .active(h_active)
    );

    dpd_activity_timer #(.TIMEOUT(V_TIMEOUT)) u_v_timer (
        .clk(clk), .rst_n(rst_n), .edge_seen(v_edge), .active(v_active)
    );

    dpd_state_ctrl #(.QUAL_CYCLES(QUAL_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .h_active(h_active), .v_active(v_active),
        .force_on(force_on), .state_q(cur_state)
    );

    // Active-low indicators, one per saving state plus the light-saving group.
    always_comb begin
        stby_n = (cur_state != PWR_STANDBY);
        susp_n = (cur_state != PWR_SUSPEND);
        off_n  = (cur_state != PWR_OFF);
        save_n = !((cur_state == PWR_STANDBY) || (cur_state == PWR_SUSPEND));
    end

endmodule

// File: rtl/dpd_power_detect_chk.sv
// Property checker for the display power state detector, bound to the top.
// Keeps its own count of consecutive non-on targets to check the qualification window.
module dpd_power_detect_chk
    import dpd_pkg::*;
#(
    parameter int QUAL_CYCLES = 163840
) (
    input logic       clk,
    input logic       rst_n,
    input logic       force_on,
    input logic       h_act,
    input logic       v_act,
    input logic [1:0] state,
    input logic       stby_n,
    input logic       susp_n,
    input logic       off_n,
    input logic       save_n
);
    logic   want_on;
    int     nonon_cnt;

    assign want_on = force_on || (h_act && v_act);

    // Count consecutive cycles spent in on with a non-on target.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   nonon_cnt <= 0;
        else if (state == 2'(PWR_ON) && !want_on)     nonon_cnt <= nonon_cnt + 1;
        else                                          nonon_cnt <= 0;
    end

    p_reset_on_r11: assert property (@(posedge clk)
        !rst_n |=> (state == 2'(PWR_ON)));

    p_single_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~stby_n, ~susp_n, ~off_n}) <= 1);

    p_group_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        save_n == (stby_n && susp_n));

    p_force_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        force_on |=> (state == 2'(PWR_ON)));

    p_fast_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'(PWR_ON)) |=>
            (state == 2'(decode_power($past(h_act), $past(v_act), $past(force_on)))));

    p_hold_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'(PWR_ON) && !want_on && nonon_cnt < QUAL_CYCLES - 1) |=>
            (state == 2'(PWR_ON)));

    p_leave_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'(PWR_ON) && !want_on && nonon_cnt == QUAL_CYCLES - 1) |=>
            (state != 2'(PWR_ON)));

endmodule

bind dpd_power_detect dpd_power_detect_chk #(.QUAL_CYCLES(QUAL_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .force_on(force_on),
    .h_act(h_active), .v_act(v_active), .state(cur_state),
    .stby_n(stby_n), .susp_n(susp_n), .off_n(off_n), .save_n(save_n)
);

// File: tb/tb_dpd_power_detect.sv
`timescale 1ns/1ps
module tb_dpd_power_detect;
    localparam int QUAL = 200;
    localparam int HTO  = 16;
    localparam int VTO  = 40;

    localparam logic [3:0] E_ON   = 4'b1111;   // {stby_n,susp_n,off_n,save_n}
    localparam logic [3:0] E_STBY = 4'b0110;
    localparam logic [3:0] E_SUSP = 4'b1010;
    localparam logic [3:0] E_OFF  = 4'b1101;

    logic clk = 1'b0, rst_n = 1'b0, hs = 1'b0, vs = 1'b0, ovr = 1'b0;
    logic stby_n, susp_n, off_n, save_n;

    int checks = 0, failures = 0;
    bit done = 1'b0, cmp_en = 1'b0;

    dpd_power_detect #(.QUAL_CYCLES(QUAL), .H_TIMEOUT(HTO), .V_TIMEOUT(VTO), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs), .force_on(ovr),
        .stby_n(stby_n), .susp_n(susp_n), .off_n(off_n), .save_n(save_n)
    );

    always #2.5 clk = ~clk;

    // Pulse generators: 1-cycle pulses every *_per cycles, inverted when *_pol is set.
    bit h_run = 0, h_pol = 0, h_lvl = 0, v_run = 0, v_pol = 0, v_lvl = 0;
    int h_per = 6, v_per = 25, h_ph = 0, v_ph = 0;
    always @(negedge clk) begin
        if (h_run) begin h_ph = (h_ph + 1) % h_per; hs <= h_pol ^ (h_ph == 0); end
        else hs <= h_lvl;
        if (v_run) begin v_ph = (v_ph + 1) % v_per; vs <= v_pol ^ (v_ph == 0); end
        else vs <= v_lvl;
    end

    // Behavioural reference: 0 on, 1 standby, 2 suspend, 3 off.
    int hq[$], vq[$];
    int hc = HTO, vc = VTO, qc = 0, mst = 0;
    always @(posedge clk) begin
        bit ha, va, he, ve;
        int tgt;
        hq.push_back(int'(hs)); if (hq.size() > 4) void'(hq.pop_front());
        vq.push_back(int'(vs)); if (vq.size() > 4) void'(vq.pop_front());
        if (!rst_n) begin
            mst = 0; qc = 0; hc = HTO; vc = VTO;
        end else begin
            ha = (hc < HTO);
            va = (vc < VTO);
            if (ovr || (ha && va)) tgt = 0;
            else if (va)           tgt = 1;
            else if (ha)           tgt = 2;
            else                   tgt = 3;
            if (mst == 0) begin
                if (tgt == 0) qc = 0;
                else if (qc == QUAL - 1) begin mst = tgt; qc = 0; end
                else qc++;
            end else begin
                mst = tgt; qc = 0;
            end
            he = (hq.size() == 4) && (hq[0] != hq[1]);
            ve = (vq.size() == 4) && (vq[0] != vq[1]);
            hc = he ? 0 : ((hc < HTO) ? hc + 1 : hc);
            vc = ve ? 0 : ((vc < VTO) ? vc + 1 : vc);
        end
    end

    function automatic logic [3:0] enc(int s);
        case (s)
            0: return E_ON;
            1: return E_STBY;
            2: return E_SUSP;
            default: return E_OFF;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Compare the design against the reference on every clock (R10 one-low rule too).
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            checks++;
            if ({stby_n, susp_n, off_n, save_n} !== enc(mst)) begin
                failures++;
                $display("FAIL %s cycle compare actual=%b expected=%b at %0t",
                         tag_of(mst), {stby_n, susp_n, off_n, save_n}, enc(mst), $time);
            end
            checks++;
            if ((int'(!stby_n) + int'(!susp_n) + int'(!off_n)) > 1) begin
                failures++;
                $display("FAIL R10 more than one low actual=%b expected=at most one",
                         {stby_n, susp_n, off_n});
            end
        end
    end

    task automatic expect_out(input logic [3:0] exp, input string tag);
        @(negedge clk);
        checks++;
        if ({stby_n, susp_n, off_n, save_n} !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag,
                     {stby_n, susp_n, off_n, save_n}, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        expect_out(E_ON, "R11 reset state");

        // R1 and R7: both lines active, positive polarity.
        h_run = 1; v_run = 1;
        wait_cyc(QUAL + 100);
        expect_out(E_ON, "R1 both active");

        // R5 and R8: horizontal stops low; mid-window still on, later standby.
        h_run = 0; h_lvl = 0;
        wait_cyc(100);
        expect_out(E_ON, "R5 mid qualification");
        wait_cyc(200);
        expect_out(E_STBY, "R2 standby after qualification R8");

        // R4, R6 and R7: vertical parked high counts as silent; move is immediate.
        v_run = 0; v_lvl = 1;
        wait_cyc(VTO + 40);
        expect_out(E_OFF, "R4 off from standby R6 R7");

        // R3 and R7: horizontal returns with negative pulses.
        h_pol = 1; h_run = 1;
        wait_cyc(20);
        expect_out(E_SUSP, "R3 suspend with inverted pulses R6");

        // R1 and R6: vertical returns, inverted too.
        v_pol = 1; v_run = 1;
        wait_cyc(50);
        expect_out(E_ON, "R1 back to on R6");

        // R5: short vertical outage is absorbed.
        v_run = 0; v_lvl = 1;
        wait_cyc(60);
        v_run = 1;
        wait_cyc(50);
        expect_out(E_ON, "R5 short outage keeps on");
        wait_cyc(QUAL);
        expect_out(E_ON, "R5 count restarted");

        // R4: both lines stop.
        h_run = 0; h_lvl = 1; v_run = 0; v_lvl = 0;
        wait_cyc(QUAL + 100);
        expect_out(E_OFF, "R4 both silent");

        // R9: override forces on from off and holds it.
        ovr = 1;
        wait_cyc(2);
        expect_out(E_ON, "R9 override from off");
        wait_cyc(QUAL + 50);
        expect_out(E_ON, "R9 override held");
        ovr = 0;
        wait_cyc(100);
        expect_out(E_ON, "R5 fresh window after override R9");
        wait_cyc(QUAL);
        expect_out(E_OFF, "R4 off after release R8");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule